// File: doc/BRIEF.md
# Dadda-Tree Significand Multiplier

This block multiplies two unsigned significands (a hidden leading bit plus the fraction bits, 24 bits each by default) and returns the full double-width product with no rounding and no truncation. It is purely combinational and holds no state. It is meant to sit inside a floating-point multiply datapath, where the exponent, sign and normalisation logic around it consumes the top product bits.

Each multiplier bit selects either a left-shifted copy of the zero-extended multiplicand or a row of zeros. The resulting rows of the partial-product matrix go into a reduction tree of full and half adders. The tree follows the Dadda height schedule 2, 3, 4, 6, 9, 13, 19, 28, where each step is the previous one times 1.5, rounded down. The tree starts at the largest target below the operand width and, at each stage, places only the adders needed to bring every column down to that stage's target. With 24-bit operands there are seven stages, and the first target is 19. A conventional adder then sums the last two rows.

Top module: `sigmul_dadda`

## Requirements
- R1: For every pair of operands, `product_o` equals the unsigned product of `mcand_i` and `mplier_i`, all 2N bits of it.
- R2: When either operand is zero, `product_o` is zero.
- R3: When `mplier_i` has only bit i set (i from 0 to N-1), `product_o` equals `mcand_i` shifted left by i, with every other bit zero.
- R4: With both operands all ones at N=24, `product_o` is 48'hFFFFFE000001.
- R5: When the top bit (bit N-1) of both operands is 1, the top two product bits (2N-1 and 2N-2) are not both zero.
- R6: When the top bit (bit N-1) of both operands is 0, the top two product bits (2N-1 and 2N-2) are both zero.
- R7: The product follows a change on either operand within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | N (24) | Multiplicand significand, unsigned |
| mplier_i | input | N (24) | Multiplier significand; each bit selects one partial-product row |
| product_o | output | 2N (48) | Full unsigned product |

## Verification
The checks assume only that both operands hold known 0/1 values once they settle. They place no constraint on value ranges, because the block has no illegal operand. The bench drives the operands only from its own tasks, one step after a rising edge, and holds them steady until the comparison on the falling edge. Each comparison therefore sees a settled value. The stimulus covers zero operands, one-hot multipliers, all-ones and alternating-bit operands, and random operands with the top bits forced set and forced clear. These patterns exercise both the deepest columns and the empty edge columns of the tree.

// File: rtl/sigmul_pkg.sv
`timescale 1ns/1ps
package sigmul_pkg;
  localparam int SIG_W = 24;

  // Dadda target height for schedule index j: 2, 3, 4, 6, 9, 13, 19, 28 ...
  function automatic int stage_height(input int j);
    int d;
    d = 2;
    for (int k = 0; k < j; k++) d = (d * 3) / 2;
    return d;
  endfunction

  // Number of reduction stages needed for an n-row matrix.
  function automatic int stage_count(input int n);
    int s;
    s = 0;
    while (stage_height(s) < n) s++;
    return s;
  endfunction
endpackage

// File: rtl/sigmul_pp_rows.sv
`timescale 1ns/1ps
module sigmul_pp_rows #(
  parameter int N = 24
) (
  input  logic [N-1:0]              mcand_i,
  input  logic [N-1:0]              mplier_i,
  output logic [N-1:0][2*N-2:0]     rows_o
);
  localparam int XW = 2 * N - 1;

  logic [XW-1:0] mcand_ext;
  assign mcand_ext = {{(N-1){1'b0}}, mcand_i};

  // Shift-and-select: no AND array, each multiplier bit picks a shifted copy or zeros.
  for (genvar r = 0; r < N; r++) begin : g_row
    assign rows_o[r] = mplier_i[r] ? (mcand_ext << r) : '0;
  end
endmodule

// File: rtl/sigmul_dadda_tree.sv
`timescale 1ns/1ps
module sigmul_dadda_tree
  import sigmul_pkg::*;
#(
  parameter int N = 24
) (
  input  logic [N-1:0][2*N-2:0] rows_i,
  output logic [2*N-1:0]        sum_o,
  output logic [2*N-1:0]        carry_o
);
  localparam int W      = 2 * N;
  localparam int STAGES = stage_count(N);

  logic [N-1:0] cur [W];
  logic [N-1:0] nxt [W];
  int           ncur [W];
  int           nnxt [W];

  // Bits outside each row's window are structurally zero; only the window feeds the tree.
  logic unused_rows;
  assign unused_rows = ^rows_i;

  always_comb begin
    int   tgt;
    int   idx;
    int   avail;
    logic x0, x1, x2;
    tgt = 0; idx = 0; avail = 0;
    x0 = 1'b0; x1 = 1'b0; x2 = 1'b0;
    for (int c = 0; c < W; c++) begin
      cur[c] = '0; nxt[c] = '0; ncur[c] = 0; nnxt[c] = 0;
    end
    // Column stacks: row r contributes to columns r .. r+N-1 only.
    for (int r = 0; r < N; r++) begin
      for (int c = r; c < r + N; c++) begin
        cur[c][ncur[c]] = rows_i[r][c];
        ncur[c]++;
      end
    end
    // Stages from the largest target below N down to 2; minimal adders per column.
    for (int s = STAGES - 1; s >= 0; s--) begin
      tgt = stage_height(s);
      for (int c = 0; c < W; c++) begin
        nxt[c] = '0; nnxt[c] = 0;
      end
      for (int c = 0; c < W; c++) begin
        idx   = 0;
        avail = ncur[c] + nnxt[c];  // nnxt[c] already holds carries from column c-1
        for (int k = 0; k < N; k++) begin
          if (avail > tgt && ncur[c] - idx >= 3 && avail - tgt >= 2) begin
            x0 = cur[c][idx]; x1 = cur[c][idx+1]; x2 = cur[c][idx+2];
            nxt[c][nnxt[c]] = x0 ^ x1 ^ x2;
            nnxt[c]++;
            if (c + 1 < W) begin
              nxt[c+1][nnxt[c+1]] = (x0 & x1) | (x2 & (x0 ^ x1));
              nnxt[c+1]++;
            end
            idx   += 3;
            avail -= 2;
          end else if (avail > tgt && ncur[c] - idx >= 2) begin
            x0 = cur[c][idx]; x1 = cur[c][idx+1];
            nxt[c][nnxt[c]] = x0 ^ x1;
            nnxt[c]++;
            if (c + 1 < W) begin
              nxt[c+1][nnxt[c+1]] = x0 & x1;
              nnxt[c+1]++;
            end
            idx   += 2;
            avail -= 1;
          end
        end
        for (int k = 0; k < N; k++) begin
          if (k >= idx && k < ncur[c]) begin
            nxt[c][nnxt[c]] = cur[c][k];
            nnxt[c]++;
          end
        end
      end
      for (int c = 0; c < W; c++) begin
        cur[c] = nxt[c]; ncur[c] = nnxt[c];
      end
    end
    for (int c = 0; c < W; c++) begin
      sum_o[c]   = (ncur[c] > 0) ? cur[c][0] : 1'b0;
      carry_o[c] = (ncur[c] > 1) ? cur[c][1] : 1'b0;
    end
  end
endmodule

// File: rtl/sigmul_cpa.sv
`timescale 1ns/1ps
module sigmul_cpa #(
  parameter int W = 48
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  // Carry out of the top column is dropped: the product fits in W bits.
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/sigmul_dadda.sv
`timescale 1ns/1ps
module sigmul_dadda
  import sigmul_pkg::*;
#(
  parameter int N = SIG_W
) (
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic [2*N-1:0] product_o
);
  localparam int W = 2 * N;

  logic [N-1:0][W-2:0] pp_rows;
  logic [W-1:0]        sum_row;
  logic [W-1:0]        carry_row;

  sigmul_pp_rows #(.N(N)) u_pp (
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .rows_o  (pp_rows)
  );

  sigmul_dadda_tree #(.N(N)) u_tree (
    .rows_i (pp_rows),
    .sum_o  (sum_row),
    .carry_o(carry_row)
  );

  sigmul_cpa #(.W(W)) u_cpa (
    .a_i  (sum_row),
    .b_i  (carry_row),
    .sum_o(product_o)
  );
endmodule

// File: rtl/sigmul_dadda_chk.sv
`timescale 1ns/1ps
module sigmul_dadda_chk #(
  parameter int N = 24
) (
  input logic [N-1:0]   mcand_i,
  input logic [N-1:0]   mplier_i,
  input logic [2*N-1:0] product_o,
  input logic [2*N-1:0] sum_row_i,
  input logic [2*N-1:0] carry_row_i
);
  localparam int W = 2 * N;

  logic [W-1:0] ref_prod;
  logic [W-1:0] row_total;
  assign ref_prod  = W'(mcand_i) * W'(mplier_i);
  assign row_total = sum_row_i + carry_row_i;

  always_comb begin
    // R1
    prod_match_chk: assert (product_o == ref_prod);
    // R1 (tree output alone, before the final adder)
    rows_match_chk: assert (row_total == ref_prod);
    if (mcand_i == '0 || mplier_i == '0) begin
      // R2
      zero_operand_chk: assert (product_o == '0);
    end
    if (mplier_i == N'(1)) begin
      // R3
      unit_mplier_chk: assert (product_o == W'(mcand_i));
    end
    if (mcand_i[N-1] && mplier_i[N-1]) begin
      // R5
      norm_top_chk: assert (product_o[W-1:W-2] != 2'b00);
    end
    if (!mcand_i[N-1] && !mplier_i[N-1]) begin
      // R6
      small_top_chk: assert (product_o[W-1:W-2] == 2'b00);
    end
  end
endmodule

bind sigmul_dadda sigmul_dadda_chk #(.N(N)) u_chk (
  .mcand_i    (mcand_i),
  .mplier_i   (mplier_i),
  .product_o  (product_o),
  .sum_row_i  (sum_row),
  .carry_row_i(carry_row)
);

// File: tb/sigmul_dadda_test.sv
`timescale 1ns/1ps
module sigmul_dadda_test;
  localparam int N = 24;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] mcand = '0;
  logic [N-1:0] mplier = '0;
  logic [W-1:0] product;
  int           checks = 0;
  int           errors = 0;
  bit           mon_on = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  sigmul_dadda #(.N(N)) uut (
    .mcand_i  (mcand),
    .mplier_i (mplier),
    .product_o(product)
  );

  function automatic logic [W-1:0] model(input logic [N-1:0] x, input logic [N-1:0] y);
    longint unsigned px, py;
    px = longint'(x);
    py = longint'(y);
    return W'(px * py);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h)", req, act, exp, mcand, mplier);
    end
  endtask

  // Per-clock reference comparison, R1
  always @(negedge clk) begin
    if (mon_on) chk("R1 monitor", product, model(mcand, mplier));
  end

  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
    @(posedge clk);
    #1;
    mcand  = x;
    mplier = y;
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] rnd();
    return N'($urandom);
  endfunction

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 initial zero operands", product, '0);
    rst_ni = 1'b1;
    mon_on = 1'b1;

    // R2: zero on either side
    apply(rnd(), '0);         chk("R2 mplier zero", product, '0);
    apply('0, rnd());         chk("R2 mcand zero", product, '0);
    apply('1, '0);            chk("R2 all-ones times zero", product, '0);
    apply('0, '1);            chk("R2 zero times all-ones", product, '0);

    // R3: one-hot multiplier selects a single shifted row
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] x;
      logic [W-1:0] e;
      x = rnd() | N'(1);
      e = '0;
      for (int k = 0; k < N; k++) e[k+i] = x[k];
      apply(x, N'(1) << i);
      chk("R3 one-hot multiplier", product, e);
    end

    // R4: all-ones corner
    apply('1, '1);            chk("R4 all ones", product, 48'hFFFFFE000001);

    // R1: directed patterns
    apply(24'hAAAAAA, 24'h555555); chk("R1 alternating", product, model(24'hAAAAAA, 24'h555555));
    apply(24'h800000, 24'h800000); chk("R1 top bits only", product, 48'h400000000000);
    apply(24'hFFFFFF, 24'h000001); chk("R1 ones times one", product, 48'h000000FFFFFF);
    apply(24'hCCCCCD, 24'h9B999A); chk("R1 significand pair", product, model(24'hCCCCCD, 24'h9B999A));

    // R1: random operands
    for (int n = 0; n < 2000; n++) begin
      logic [N-1:0] x, y;
      x = rnd(); y = rnd();
      apply(x, y);
      chk("R1 random", product, model(x, y));
    end

    // R5: both top bits set
    for (int n = 0; n < 300; n++) begin
      logic [N-1:0] x, y;
      x = rnd(); y = rnd();
      x[N-1] = 1'b1; y[N-1] = 1'b1;
      apply(x, y);
      chk("R5 normalized top bits", W'(product[W-1:W-2] != 2'b00), W'(1));
    end

    // R6: both top bits clear
    for (int n = 0; n < 300; n++) begin
      logic [N-1:0] x, y;
      x = rnd(); y = rnd();
      x[N-1] = 1'b0; y[N-1] = 1'b0;
      apply(x, y);
      chk("R6 small operands top bits", W'(product[W-1:W-2]), '0);
    end

    // R7: changes inside one clock phase, no edge in between
    mon_on = 1'b0;
    @(posedge clk);
    #0.5;
    mcand = 24'h123456; mplier = 24'h00ABCD;
    #0.5;
    chk("R7 immediate response", product, model(24'h123456, 24'h00ABCD));
    #0.5;
    mplier = 24'hFEDCBA;
    #0.5;
    chk("R7 second change same phase", product, model(24'h123456, 24'hFEDCBA));
    mon_on = 1'b1;

    apply('0, '0);
    @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule